// File: doc/BRIEF.md
# SDRAM Bank State Protocol Monitor

This block watches the command bus of a single-data-rate SDRAM and keeps its own model of the four banks. For each bank it records whether a row is open and which row it is. It also runs the precharge recovery window, the mode-load recovery window and the automatic close that follows a burst issued with auto precharge. Every command is judged against that model. The first illegal command sets a sticky error flag and a code that names the rule that was broken.

The monitor is placed beside a memory controller, in simulation or on silicon, as a passive observer. It takes the already decoded command, the bank select, the address bus and the current burst-length code. The recovery times are parameters. Illegal commands do not change the bank model, so one bad command does not produce a chain of follow-on errors. Nothing happens on a clock edge where the clock enable is low.

Top module: `sdram_bank_monitor`

## Requirements
- R1: `cmd_i` is encoded as 0 deselect, 1 NOP, 2 ACTIVE, 3 READ, 4 WRITE, 5 PRECHARGE, 6 BURST TERMINATE, 7 LOAD MODE. A legal ACTIVE opens bank `ba_i` on the next edge and shows the whole `addr_i` on that bank's slice of `bank_row_o`. The row stays open until that bank is precharged.
- R2: An ACTIVE to a bank that already has an open row sets error code 1. The stored row is not changed.
- R3: On PRECHARGE, `addr_i[10]` high closes every bank and `ba_i` is ignored. `addr_i[10]` low closes only bank `ba_i`.
- R4: A precharged bank accepts ACTIVE from the T_RP-th edge after the closing edge, and `bank_ready_o` rises at that point. An ACTIVE issued earlier sets code 2.
- R5: A READ or WRITE to a bank with no open row sets code 3.
- R6: LOAD MODE while any bank is open, recovering, or waiting on auto precharge sets code 4.
- R7: Any command other than NOP or deselect on the first T_MRD-1 edges after a legal LOAD MODE sets code 5. On a later edge the same command is legal.
- R8: `burst_code_i` values 0 to 3 give bursts of 1, 2, 4 and 8 beats. A READ or WRITE with `addr_i[10]` high closes its bank exactly that many edges later, and the bank then recovers for T_RP cycles. Before the bank closes, an ACTIVE, READ, WRITE or PRECHARGE that targets it sets code 6. So does a precharge of all banks.
- R9: When `burst_code_i[2]` is high (full page), `addr_i[10]` on READ or WRITE is not honoured and the row stays open.
- R10: BURST TERMINATE applies to the bank of the most recent legal READ or WRITE. If that bank has auto precharge pending, it closes on the terminate edge. A pending close in any other bank keeps its own schedule.
- R11: NOP and deselect change no bank state and do not stop the recovery or auto-precharge countdowns.
- R12: After reset all banks are closed and ready, and `err_o` is 0 with code 0. `err_o` and `err_code_o` keep the first violation until reset. Illegal commands leave the bank model unchanged, and legal commands still update it.
- R13: On an edge with `cke_i` low, no command is checked or applied and every countdown holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable; state advances only when high |
| cmd_i | input | 3 | Decoded command code |
| ba_i | input | 2 | Bank select |
| addr_i | input | 12 | Address bus (row, or bit 10 as qualifier) |
| burst_code_i | input | 3 | Burst length code; bit 2 means full page |
| bank_open_o | output | 4 | Per-bank open-row flag |
| bank_ready_o | output | 4 | Per-bank closed, recovered and free of pending close |
| bank_row_o | output | 48 | Open row per bank, bank 0 in the low 12 bits |
| mrd_busy_o | output | 1 | Mode-load recovery window running |
| err_o | output | 1 | Sticky violation flag |
| err_code_o | output | 3 | Code of the first violation |

## Verification
The sweeps place an ACTIVE after every possible gap following a precharge, and a command after every possible gap following a mode load. A window that is off by one cycle therefore rejects a legal command or accepts an early one. Auto precharge is checked cycle by cycle for every burst length, on both READ and WRITE, so a close scheduled one beat early or late, or a recovery started from the wrong edge, shows up on `bank_open_o` or `bank_ready_o`. Burst terminate is tried on the bank that carries the pending close and also past it onto another bank's READ. A design that closed the wrong bank, or closed every pending bank, would leave the wrong open pattern. Sticky-error, illegal-command, all-bank and clock-enable cases confirm that a rejected or gated command leaves the model untouched.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [2:0] {
    CMD_DESEL = 3'd0,
    CMD_NOP   = 3'd1,
    CMD_ACT   = 3'd2,
    CMD_RD    = 3'd3,
    CMD_WR    = 3'd4,
    CMD_PRE   = 3'd5,
    CMD_BST   = 3'd6,
    CMD_LMR   = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_ACT_OPEN = 3'd1,
    ERR_ACT_TRP  = 3'd2,
    ERR_RW_IDLE  = 3'd3,
    ERR_LMR_BUSY = 3'd4,
    ERR_MRD_WAIT = 3'd5,
    ERR_AP_BUSY  = 3'd6
  } err_e;

  function automatic logic is_exec(cmd_e c);
    return !(c == CMD_DESEL || c == CMD_NOP);
  endfunction

endpackage

// File: rtl/sdram_cmd_rules.sv
module sdram_cmd_rules
  import sdram_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  cmd_e                 cmd_i,
  input  logic [BA_W-1:0]      ba_i,
  input  logic                 all_i,
  input  logic [NUM_BANKS-1:0] open_i,
  input  logic [NUM_BANKS-1:0] trp_busy_i,
  input  logic [NUM_BANKS-1:0] ap_pend_i,
  input  logic                 mrd_busy_i,
  output err_e                 code_o
);

  always_comb begin
    code_o = ERR_NONE;
    if (mrd_busy_i && is_exec(cmd_i)) begin
      code_o = ERR_MRD_WAIT;
    end else begin
      case (cmd_i)
        CMD_ACT: begin
          if (ap_pend_i[ba_i])       code_o = ERR_AP_BUSY;
          else if (open_i[ba_i])     code_o = ERR_ACT_OPEN;
          else if (trp_busy_i[ba_i]) code_o = ERR_ACT_TRP;
        end
        CMD_RD, CMD_WR: begin
          if (ap_pend_i[ba_i])       code_o = ERR_AP_BUSY;
          else if (!open_i[ba_i])    code_o = ERR_RW_IDLE;
        end
        CMD_PRE: begin
          if (all_i ? |ap_pend_i : ap_pend_i[ba_i]) code_o = ERR_AP_BUSY;
        end
        CMD_LMR: begin
          if (|(open_i | trp_busy_i | ap_pend_i)) code_o = ERR_LMR_BUSY;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track #(
  parameter int ROW_W  = 12,
  parameter int T_RP   = 3,
  parameter int BEAT_W = 4,
  localparam int TRP_W = $clog2(T_RP + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic              act_i,
  input  logic              pre_i,
  input  logic              ap_arm_i,
  input  logic              bst_cut_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [BEAT_W-1:0] beats_i,
  output logic              open_o,
  output logic [ROW_W-1:0]  row_o,
  output logic              trp_busy_o,
  output logic              ap_pend_o
);

  logic              open_q;
  logic [ROW_W-1:0]  row_q;
  logic [TRP_W-1:0]  trp_q;
  logic [BEAT_W-1:0] ap_q;
  logic              close;

  // explicit precharge, last beat of an auto-precharge burst, or a cut burst
  assign close = (pre_i && open_q) || (ap_q == BEAT_W'(1)) ||
                 (bst_cut_i && ap_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      row_q  <= '0;
      trp_q  <= '0;
      ap_q   <= '0;
    end else if (cke_i) begin
      if (trp_q != '0) trp_q <= trp_q - TRP_W'(1);
      if (act_i) begin
        open_q <= 1'b1;
        row_q  <= row_i;
      end else if (close) begin
        open_q <= 1'b0;
        ap_q   <= '0;
        trp_q  <= TRP_W'(T_RP - 1);
      end else if (ap_arm_i) begin
        ap_q <= beats_i;
      end else if (ap_q != '0) begin
        ap_q <= ap_q - BEAT_W'(1);
      end
    end
  end

  assign open_o     = open_q;
  assign row_o      = row_q;
  assign trp_busy_o = (trp_q != '0);
  assign ap_pend_o  = (ap_q != '0);

  // R1
  act_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i && act_i |=> open_q && row_q == $past(row_i));

  // R4 (also R2: activation only reaches a closed bank)
  act_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i && act_i |-> !open_q && trp_q == '0);

  // R8
  ap_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i && ap_q == BEAT_W'(1) |=> !open_q);

  // R10
  bst_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i && bst_cut_i && ap_q != '0 |=> !open_q && ap_q == '0);

  // R13
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |=> $stable(open_q) && $stable(trp_q) && $stable(ap_q));

endmodule

// File: rtl/sdram_mrd_timer.sv
module sdram_mrd_timer #(
  parameter int T_MRD = 2,
  localparam int CNT_W = $clog2(T_MRD + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cke_i,
  input  logic load_i,
  output logic busy_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (cke_i) begin
      if (load_i)              cnt_q <= CNT_W'(T_MRD - 1);
      else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign busy_o = (cnt_q != '0);

  // R7
  lmr_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i && load_i |-> !busy_o);

endmodule

// File: rtl/sdram_bank_monitor.sv
module sdram_bank_monitor
  import sdram_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int AP_BIT    = 10,
  parameter int T_RP      = 3,
  parameter int T_MRD     = 2,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cke_i,
  input  logic [2:0]                 cmd_i,
  input  logic [BA_W-1:0]            ba_i,
  input  logic [ROW_W-1:0]           addr_i,
  input  logic [2:0]                 burst_code_i,
  output logic [NUM_BANKS-1:0]       bank_open_o,
  output logic [NUM_BANKS-1:0]       bank_ready_o,
  output logic [NUM_BANKS*ROW_W-1:0] bank_row_o,
  output logic                       mrd_busy_o,
  output logic                       err_o,
  output logic [2:0]                 err_code_o
);

  localparam int BEAT_W = 4;

  cmd_e                 cmd;
  err_e                 code, code_q;
  logic                 legal, flag_a10, full_page, is_rw, err_q;
  logic [BEAT_W-1:0]    beats;
  logic [BA_W-1:0]      last_q;
  logic [NUM_BANKS-1:0] open_v, trp_v, ap_v;
  logic                 mrd_busy;

  assign cmd       = cmd_e'(cmd_i);
  assign flag_a10  = addr_i[AP_BIT];
  assign full_page = burst_code_i[2];
  assign beats     = BEAT_W'(1) << burst_code_i[1:0];
  assign is_rw     = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign legal     = cke_i && (code == ERR_NONE);

  sdram_cmd_rules #(.NUM_BANKS(NUM_BANKS)) u_rules (
    .cmd_i      (cmd),
    .ba_i       (ba_i),
    .all_i      (flag_a10),
    .open_i     (open_v),
    .trp_busy_i (trp_v),
    .ap_pend_i  (ap_v),
    .mrd_busy_i (mrd_busy),
    .code_o     (code)
  );

  sdram_mrd_timer #(.T_MRD(T_MRD)) u_mrd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cke_i  (cke_i),
    .load_i (legal && cmd == CMD_LMR),
    .busy_o (mrd_busy)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             sel;
    logic [ROW_W-1:0] row_w;
    assign sel = (ba_i == BA_W'(b));

    sdram_bank_track #(.ROW_W(ROW_W), .T_RP(T_RP), .BEAT_W(BEAT_W)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cke_i      (cke_i),
      .act_i      (legal && cmd == CMD_ACT && sel),
      .pre_i      (legal && cmd == CMD_PRE && (flag_a10 || sel)),
      .ap_arm_i   (legal && is_rw && sel && flag_a10 && !full_page),
      .bst_cut_i  (legal && cmd == CMD_BST && last_q == BA_W'(b)),
      .row_i      (addr_i),
      .beats_i    (beats),
      .open_o     (open_v[b]),
      .row_o      (row_w),
      .trp_busy_o (trp_v[b]),
      .ap_pend_o  (ap_v[b])
    );

    assign bank_row_o[b*ROW_W +: ROW_W] = row_w;
    assign bank_ready_o[b] = !open_v[b] && !trp_v[b] && !ap_v[b];
  end

  // bank of the most recent accepted access, target of BURST TERMINATE
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               last_q <= '0;
    else if (legal && is_rw)   last_q <= ba_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      code_q <= ERR_NONE;
    end else if (cke_i && code != ERR_NONE && !err_q) begin
      err_q  <= 1'b1;
      code_q <= code;
    end
  end

  assign bank_open_o = open_v;
  assign mrd_busy_o  = mrd_busy;
  assign err_o       = err_q;
  assign err_code_o  = code_q;

  // R12
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q && $stable(code_q));

  // R5
  rw_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i && is_rw && !open_v[ba_i] |=> err_q);

  // R6
  lmr_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i && cmd == CMD_LMR && !(&bank_ready_o) |=> err_q);

  // R7
  mrd_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i && mrd_busy && is_exec(cmd) |=> err_q);

  // R9
  full_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i && is_rw && full_page && open_v[ba_i] |=> open_v[$past(ba_i)]);

  // R3
  pre_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i && cmd == CMD_PRE && flag_a10 && ap_v == '0 && !mrd_busy
    |=> open_v == '0);

  // R11
  idle_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i && !is_exec(cmd) && ap_v == '0 |=> $stable(open_v));

endmodule

// File: tb/sim_sdram_bank_monitor.sv
`timescale 1ns/1ps
module sim_sdram_bank_monitor;

  localparam int NB = 4;
  localparam int RW = 12;
  localparam int TRP = 3;
  localparam int TMRD = 2;
  localparam logic [2:0] C_DES = 3'd0, C_NOP = 3'd1, C_ACT = 3'd2, C_RD = 3'd3,
                         C_WR = 3'd4, C_PRE = 3'd5, C_BST = 3'd6, C_LMR = 3'd7;
  localparam int A10 = 12'h400;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cke = 1'b1;
  logic [2:0]    cmd = C_NOP;
  logic [1:0]    ba = '0;
  logic [RW-1:0] addr = '0;
  logic [2:0]    bcode = 3'd2;
  logic [NB-1:0] open_o, ready_o;
  logic [NB*RW-1:0] rows_o;
  logic          mrd_o, err_o;
  logic [2:0]    code_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  sdram_bank_monitor #(.NUM_BANKS(NB), .ROW_W(RW), .AP_BIT(10), .T_RP(TRP), .T_MRD(TMRD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cmd_i(cmd), .ba_i(ba), .addr_i(addr),
    .burst_code_i(bcode), .bank_open_o(open_o), .bank_ready_o(ready_o),
    .bank_row_o(rows_o), .mrd_busy_o(mrd_o), .err_o(err_o), .err_code_o(code_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] c, input int b, input int a);
    cmd = c; ba = 2'(b); addr = RW'(a);
    @(posedge clk); #1;
    cmd = C_NOP; ba = '0; addr = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) step(C_NOP, 0, 0);
  endtask

  task automatic reset_dut;
    rst_n = 1'b0; cke = 1'b1; cmd = C_NOP; ba = '0; addr = '0; bcode = 3'd2;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    summary();
  end

  initial begin
    reset_dut();
    // R12 reset state
    chk("R12", "reset open", int'(open_o), 0);
    chk("R12", "reset ready", int'(ready_o), 15);
    chk("R12", "reset err", int'(err_o), 0);
    chk("R12", "reset code", int'(code_o), 0);

    // R1 open every bank with a distinct row
    for (int b = 0; b < NB; b++) begin
      step(C_ACT, b, (b * 12'h155 + 7) & 12'hFFF);
      chk("R1", "open bit", int'(open_o[b]), 1);
      chk("R1", "row", int'(rows_o[b*RW +: RW]), (b * 12'h155 + 7) & 12'hFFF);
    end
    chk("R1", "all open", int'(open_o), 15);
    chk("R1", "no err", int'(err_o), 0);

    // R2 activate an open bank
    step(C_ACT, 2, 12'hABC);
    chk("R2", "code", int'(code_o), 1);
    chk("R2", "row kept", int'(rows_o[2*RW +: RW]), (2 * 12'h155 + 7) & 12'hFFF);

    // R3 single and all-bank precharge
    reset_dut();
    step(C_ACT, 0, 1); step(C_ACT, 1, 2); step(C_ACT, 2, 3);
    step(C_PRE, 1, 0);
    chk("R3", "single close", int'(open_o), 5);
    step(C_PRE, 3, A10);
    chk("R3", "all close ba ignored", int'(open_o), 0);
    chk("R3", "no err", int'(err_o), 0);

    // R4 / R11 sweep of the gap between precharge and activate
    for (int b = 0; b < NB; b++) begin
      for (int n = 0; n <= TRP; n++) begin
        reset_dut();
        step(C_ACT, b, 5);
        step(C_PRE, b, 0);
        chk("R4", "ready after pre", int'(ready_o[b]), 0);
        for (int i = 0; i < n; i++) begin
          step((i % 2) ? C_DES : C_NOP, 0, 0);
          chk("R11", "ready in window", int'(ready_o[b]), (i + 1 >= TRP - 1) ? 1 : 0);
        end
        step(C_ACT, b, 6);
        chk("R4", "act code", int'(code_o), (n >= TRP - 1) ? 0 : 2);
        chk("R4", "act open", int'(open_o[b]), (n >= TRP - 1) ? 1 : 0);
      end
    end

    // R5 access to a closed bank
    reset_dut();
    step(C_RD, 1, 0);
    chk("R5", "read idle", int'(code_o), 3);
    chk("R5", "open unchanged", int'(open_o), 0);
    reset_dut();
    step(C_WR, 3, 0);
    chk("R5", "write idle", int'(code_o), 3);

    // R6 mode load while busy
    reset_dut();
    step(C_ACT, 0, 1);
    step(C_LMR, 0, 0);
    chk("R6", "lmr open", int'(code_o), 4);
    reset_dut();
    step(C_ACT, 0, 1); step(C_PRE, 0, 0);
    step(C_LMR, 0, 0);
    chk("R6", "lmr recovering", int'(code_o), 4);
    reset_dut();
    step(C_LMR, 0, 0);
    chk("R6", "lmr legal", int'(err_o), 0);
    chk("R7", "mrd busy", int'(mrd_o), (TMRD > 1) ? 1 : 0);

    // R7 gap sweep after mode load
    for (int n = 0; n <= TMRD; n++) begin
      reset_dut();
      step(C_LMR, 0, 0);
      idle(n);
      step(C_ACT, 0, 1);
      chk("R7", "act after lmr", int'(code_o), (n < TMRD - 1) ? 5 : 0);
    end

    // R8 auto precharge timeline for every burst length, read and write
    for (int bc = 0; bc < 4; bc++) begin
      for (int op = 0; op < 2; op++) begin
        int bl;
        bl = 1 << bc;
        reset_dut();
        bcode = 3'(bc);
        step(C_ACT, 1, 9);
        step(op ? C_WR : C_RD, 1, A10);
        for (int n = 1; n <= bl + TRP; n++) begin
          idle(1);
          chk("R8", "ap open", int'(open_o[1]), (n < bl) ? 1 : 0);
          chk("R8", "ap ready", int'(ready_o[1]), (n >= bl + TRP - 1) ? 1 : 0);
        end
        chk("R8", "ap no err", int'(err_o), 0);
      end
    end
    reset_dut();
    bcode = 3'd3;
    step(C_ACT, 2, 1); step(C_RD, 2, A10);
    step(C_WR, 2, 0);
    chk("R8", "write during ap", int'(code_o), 6);
    reset_dut();
    bcode = 3'd3;
    step(C_ACT, 2, 1); step(C_WR, 2, A10);
    step(C_ACT, 2, 0);
    chk("R8", "act during ap", int'(code_o), 6);

    // R9 full page ignores auto precharge
    reset_dut();
    bcode = 3'd7;
    step(C_ACT, 0, 4); step(C_RD, 0, A10);
    idle(20);
    chk("R9", "row open", int'(open_o[0]), 1);
    chk("R9", "no err", int'(err_o), 0);
    step(C_PRE, 0, 0);
    chk("R9", "closed by pre", int'(open_o[0]), 0);

    // R10 terminate on the pending bank
    reset_dut();
    bcode = 3'd3;
    step(C_ACT, 0, 4); step(C_RD, 0, A10);
    idle(2);
    step(C_BST, 0, 0);
    chk("R10", "cut closes", int'(open_o[0]), 0);
    chk("R10", "recovering", int'(ready_o[0]), 0);
    idle(TRP - 2);
    chk("R10", "not yet ready", int'(ready_o[0]), 0);
    idle(1);
    chk("R10", "ready", int'(ready_o[0]), 1);
    // R10 terminate lands on a later access in another bank
    reset_dut();
    bcode = 3'd3;
    step(C_ACT, 0, 4); step(C_ACT, 1, 5);
    step(C_RD, 0, A10); step(C_RD, 1, 0);
    step(C_BST, 0, 0);
    chk("R10", "other bank open", int'(open_o), 3);
    idle(5);
    chk("R10", "still pending", int'(open_o[0]), 1);
    idle(1);
    chk("R10", "own schedule close", int'(open_o), 2);
    chk("R10", "no err", int'(err_o), 0);

    // R12 first code sticks, illegal commands do not touch state
    reset_dut();
    step(C_RD, 0, 0);
    step(C_ACT, 0, 5);
    step(C_ACT, 0, 9);
    chk("R12", "first code kept", int'(code_o), 3);
    chk("R12", "err held", int'(err_o), 1);
    chk("R12", "legal act applied", int'(open_o[0]), 1);
    chk("R12", "illegal act ignored", int'(rows_o[0 +: RW]), 5);

    // R13 clock enable low
    reset_dut();
    cke = 1'b0;
    step(C_RD, 0, 0);
    chk("R13", "no check", int'(err_o), 0);
    step(C_ACT, 0, 3);
    chk("R13", "no apply", int'(open_o[0]), 0);
    cke = 1'b1;
    step(C_ACT, 0, 3); step(C_PRE, 0, 0);
    cke = 1'b0;
    idle(3);
    chk("R13", "countdown frozen", int'(ready_o[0]), 0);
    cke = 1'b1;
    idle(TRP - 2);
    chk("R13", "resumes", int'(ready_o[0]), 0);
    idle(1);
    chk("R13", "ready", int'(ready_o[0]), 1);

    summary();
  end

endmodule